// File: doc/BRIEF.md
# Vector Length Control Register

This block is a 64-bit system control register. It holds a requested vector length code for the two lower privilege levels and turns that request into the length the hardware actually uses. Software writes the register through a write port and reads the stored value back through a direct-read port. A length cap comes in from the more privileged levels, and a parameter mask lists the vector lengths that the hardware implements.

The effective code has two limits. First it is clipped to the inherited cap. Then it is rounded down to the nearest implemented length. The block outputs this effective code and its length in bits. A direct read always returns the raw stored code, never the constrained one. A write is forwarded to the effective outputs in the same cycle, so a use that follows the write needs no extra synchronisation. A separate select output shows when the hypervisor host configuration takes user-level length control away from this register.

Top module: `vlen_ctrl_reg`

## Requirements
- R1: From reset until the first write, the effective code is an implemented code that does not exceed the cap, whatever the stored reset value is.
- R2: When `wr_en` is high at a rising clock edge, bits [3:0] of `wr_data` are stored, and they appear on `rd_data[3:0]` from the next cycle on.
- R3: `rd_data[63:4]` always reads as zero, even after a write with those bits set.
- R4: The effective code never exceeds `cap_code`. When the source code is above the cap, the cap is the value that gets rounded.
- R5: The effective code is the largest code k such that k is no greater than min(source, cap) and bit k of the implemented mask is set. Bit 0 of the mask is always treated as set.
- R6: `rd_data[3:0]` returns the stored code unchanged, even when the cap or the mask reduces the effective code.
- R7: In a cycle with `wr_en` high, the source code for the effective output is `wr_data[3:0]` rather than the stored code.
- R8: `eff_bits` equals (eff_code + 1) × 128.
- R9: `user_len_ext` is high exactly when `host_mode`, `trap_gen` and `hyp_en` are all high, in the same cycle.
- R10: When `wr_en` is low, the stored code and `rd_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 64 | Write data; only bits [3:0] are kept |
| cap_code | input | 4 | Length cap inherited from the more privileged levels |
| host_mode | input | 1 | Hypervisor host mode is set |
| trap_gen | input | 1 | Hypervisor general trap bit is set |
| hyp_en | input | 1 | Hypervisor level is enabled in the current security state |
| rd_data | output | 64 | Direct-read value: the raw stored code, with zeros above it |
| eff_code | output | 4 | Effective length code after the cap and the rounding |
| eff_bits | output | 12 | Effective vector length in bits |
| user_len_ext | output | 1 | The user-level length comes from elsewhere, not from this register |

## Verification
A write and the indirect use of the length can fall in the same cycle. In that cycle the forwarded write data must drive the effective outputs, while the direct read still shows the old stored code until the next edge. The bench provokes this collision with writes issued under caps both above and below the written code. On every clock it compares the forwarded effective code, and the unchanged raw read, against a behavioural model that scans the mask downward.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  localparam int REG_W_DEF  = 64;
  localparam int LEN_W_DEF  = 4;
  localparam int GRAN_LOG2  = 7;   // 128-bit granule
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/vlen_rst_sync.sv
module vlen_rst_sync #(
  parameter int DEPTH = vlen_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[DEPTH-1];
endmodule

// File: rtl/vlen_len_store.sv
module vlen_len_store #(
  parameter int LEN_W = vlen_pkg::LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] src_len
);
  logic [LEN_W-1:0] len_d;

  always_comb begin
    len_d   = wr_len;
    src_len = wr_en ? wr_len : len_q;   // same-cycle forwarding
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= '0;
    else if (wr_en) len_q <= len_d;
  end
endmodule

// File: rtl/vlen_round_down.sv
module vlen_round_down #(
  parameter int                     LEN_W    = vlen_pkg::LEN_W_DEF,
  parameter logic [(1<<LEN_W)-1:0]  IMPL_SET = '1
) (
  input  logic [LEN_W-1:0] src_len,
  input  logic [LEN_W-1:0] cap_len,
  output logic [LEN_W-1:0] out_len
);
  localparam int NUM_LEN = 1 << LEN_W;
  localparam logic [NUM_LEN-1:0] SET_FIX = IMPL_SET | NUM_LEN'(1);

  logic [LEN_W-1:0] capped;

  always_comb begin
    capped  = (src_len < cap_len) ? src_len : cap_len;
    out_len = '0;
    for (int i = 0; i < NUM_LEN; i++) begin
      if (SET_FIX[i] && (i <= int'(capped))) out_len = i[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/vlen_ctrl_reg.sv
module vlen_ctrl_reg #(
  parameter int                    REG_W    = vlen_pkg::REG_W_DEF,
  parameter int                    LEN_W    = vlen_pkg::LEN_W_DEF,
  parameter logic [(1<<LEN_W)-1:0] IMPL_SET = 16'h808B
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [REG_W-1:0]                     wr_data,
  input  logic [LEN_W-1:0]                     cap_code,
  input  logic                                 host_mode,
  input  logic                                 trap_gen,
  input  logic                                 hyp_en,
  output logic [REG_W-1:0]                     rd_data,
  output logic [LEN_W-1:0]                     eff_code,
  output logic [LEN_W+vlen_pkg::GRAN_LOG2:0]   eff_bits,
  output logic                                 user_len_ext
);
  localparam int NUM_LEN = 1 << LEN_W;
  localparam int BITS_W  = LEN_W + vlen_pkg::GRAN_LOG2 + 1;
  localparam logic [NUM_LEN-1:0] SET_FIX = IMPL_SET | NUM_LEN'(1);

  logic             rst_int_n;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] src_len;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:LEN_W];

  vlen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  vlen_len_store #(.LEN_W(LEN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_len  (wr_data[LEN_W-1:0]),
    .len_q   (len_q),
    .src_len (src_len)
  );

  vlen_round_down #(.LEN_W(LEN_W), .IMPL_SET(IMPL_SET)) u_round (
    .src_len (src_len),
    .cap_len (cap_code),
    .out_len (eff_code)
  );

  always_comb begin
    rd_data      = {{(REG_W-LEN_W){1'b0}}, len_q};
    eff_bits     = (BITS_W'(eff_code) + BITS_W'(1)) << vlen_pkg::GRAN_LOG2;
    user_len_ext = host_mode & trap_gen & hyp_en;
  end

  // R4
  eff_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    eff_code <= cap_code);

  // R5
  eff_impl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    SET_FIX[eff_code]);

  // R7
  fwd_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> eff_code <= wr_data[LEN_W-1:0]);

  // R2
  len_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> rd_data[LEN_W-1:0] == $past(wr_data[LEN_W-1:0]));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |=> $stable(rd_data));

  // R9
  ext_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    user_len_ext |-> (hyp_en && host_mode && trap_gen));
endmodule

// File: tb/vlen_ctrl_reg_test.sv
module vlen_ctrl_reg_test;
  localparam logic [15:0] MASK = 16'h808B;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [3:0]  cap_code;
  logic        host_mode, trap_gen, hyp_en;
  logic [63:0] rd_data;
  logic [3:0]  eff_code;
  logic [11:0] eff_bits;
  logic        user_len_ext;

  int tests = 0;
  int fails = 0;
  int model_len = -1;   // -1: unknown reset value
  bit done = 0;

  always #2.5 clk = ~clk;

  vlen_ctrl_reg #(.IMPL_SET(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cap_code(cap_code), .host_mode(host_mode), .trap_gen(trap_gen),
    .hyp_en(hyp_en), .rd_data(rd_data), .eff_code(eff_code),
    .eff_bits(eff_bits), .user_len_ext(user_len_ext)
  );

  function automatic int round_ref(int src, int cap);
    int m = (src < cap) ? src : cap;
    for (int k = m; k > 0; k--) if (MASK[k]) return k;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int src, ec;
    chk(rd_data[63:4] == 60'd0, "R3", rd_data, rd_data[3:0]);
    chk(user_len_ext == (host_mode & trap_gen & hyp_en), "R9",
        user_len_ext, host_mode & trap_gen & hyp_en);
    if (!wr_en && model_len < 0) begin
      // R1: reset value unknown; check only the constraints
      chk(eff_code <= cap_code && MASK[eff_code], "R1", eff_code, cap_code);
    end else begin
      src = wr_en ? int'(wr_data[3:0]) : model_len;
      ec  = round_ref(src, cap_code);
      chk(eff_code == ec[3:0], wr_en ? "R7" : (cap_code < src ? "R4" : "R5"), eff_code, ec);
      chk(eff_bits == 12'((ec + 1) * 128), "R8", eff_bits, (ec + 1) * 128);
    end
    if (model_len >= 0)
      chk(rd_data[3:0] == model_len[3:0], (int'(eff_code) < model_len) ? "R6" : "R10",
          rd_data[3:0], model_len);
  endtask

  task automatic step(input bit we, input logic [63:0] wd, input logic [3:0] cap,
                      input logic [2:0] hv);
    @(negedge clk);
    wr_en = we; wr_data = wd; cap_code = cap;
    {host_mode, trap_gen, hyp_en} = hv;
    #1;
    compare();
    @(posedge clk);
    if (we) model_len = int'(wd[3:0]);   // R2
    #0.5;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0; cap_code = 4'hF;
    host_mode = 0; trap_gen = 0; hyp_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle cycles with unknown reset value, various caps
    for (int i = 0; i < 8; i++) step(0, '0, 4'(i * 2), 3'(i));
    // R2/R3: write with all upper bits set
    step(1, 64'hFFFF_FFFF_FFFF_FFF7, 4'hF, 3'b000);
    step(0, '0, 4'hF, 3'b111);
    // R6: cap and mask reduce effective, raw read unchanged
    step(0, '0, 4'h2, 3'b110);
    step(0, '0, 4'h0, 3'b101);
    // R7: write collides with indirect use, cap above and below
    step(1, 64'h0000_0000_0000_000F, 4'h5, 3'b011);
    step(1, 64'h0000_0000_0000_0002, 4'hF, 3'b111);
    step(1, 64'h0000_0000_0000_0006, 4'h6, 3'b000);
    // R5: sweep every code against full cap
    for (int c = 0; c < 16; c++) step(1, 64'(c), 4'hF, 3'b000);
    // R10: holds across idle cycles with changing cap
    for (int c = 0; c < 16; c++) step(0, 64'hDEAD_BEEF_0000_0000, 4'(c), 3'(c));
    // random mix
    for (int i = 0; i < 400; i++)
      step(1'($urandom % 2), {$urandom, $urandom}, 4'($urandom), 3'($urandom));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule